// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches a group of general-purpose input pads and turns selected input activity into interrupt events. Each pad has its own two-bit detection mode and a polarity-swap bit. Together these choose what counts as an event: a high level, a rising edge, any transition, or nothing at all. Detected events land in a sticky pending register. Software clears a pending bit by writing a one to it.

A second register holds a per-pad enable mask. The block drives one interrupt line, which is the registered OR of every pending bit whose enable bit is also set. Software reaches both registers through a small single-cycle register port. The port has a write strobe, a one-bit address and a read path that follows the address.

The pad levels arrive already synchronized to the block clock. The asynchronous reset input is asserted immediately, but its release is resynchronized inside the block.

Top module: `gpio_event_detector`

## Requirements
- R1: While reset is active and after it is released, the pending register, the enable register and `irq_o` are all zero.
- R2: Mode code 0 (level) sets a pad's pending bit on every clock edge at which the pad level XOR its polarity bit is 1. The pending bit is visible one cycle after that edge.
- R3: Mode code 1 (edge) sets the pending bit when the polarity-adjusted level goes from 0 to 1 between two consecutive edges. With the polarity bit at 0 this is a rising pad. With the polarity bit at 1 it is a falling pad.
- R4: Mode code 3 (any transition) sets the pending bit whenever the raw pad level differs from its value at the previous edge. The polarity bit has no effect in this mode.
- R5: Mode code 2 (off) never sets the pending bit, whatever the pad does.
- R6: A write to address 0 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R7: When a detected event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R8: `irq_o` is a register loaded with the OR of (pending AND enable). It therefore follows a change of pending or enable one cycle later.
- R9: A write to address 1 loads the enable register. `reg_rdata_o` shows the pending register when `reg_addr_i` is 0 and the enable register when it is 1.
- R10: The edge history starts at 0 after reset. Toggling a pad's polarity bit while the pad level stays steady creates no edge event.
- R11: Writing zero to the enable register and all ones to the pending register leaves `irq_o` low and the pending register zero, provided no pad keeps producing events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, release resynchronized |
| pad_i | input | NUM_PADS | Synchronized pad levels |
| evt_mode_i | input | 2*NUM_PADS | Per-pad mode, pad k at bits [2k+1:2k]: 0 level, 1 edge, 2 off, 3 any transition |
| pad_inv_i | input | NUM_PADS | Per-pad polarity swap applied before level and edge detection |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects pending, 1 selects enable |
| reg_wdata_i | input | NUM_PADS | Write data |
| reg_rdata_o | output | NUM_PADS | Read data of the addressed register |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with NUM_PADS = 8. At that size, random draws regularly hit every mode code and both polarities on every pad. They also hit clear writes that collide with fresh events, and enable masks anywhere from empty to full. Directed sequences pin down the level re-set after a clear, falling-edge detection under polarity swap, and the invariance of any-transition mode to the polarity bit. They also cover polarity toggling on a steady pad and the mask-all-and-clear sequence. Every cycle, the bench compares the read path and the interrupt line against a model that steps the pending, enable and history state.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_EDGE  = 2'd1,
    EVT_OFF   = 2'd2,
    EVT_ANY   = 2'd3
  } evt_mode_e;

  localparam logic ADDR_PEND = 1'b0;
  localparam logic ADDR_MASK = 1'b1;
endpackage

// File: rtl/gpio_evt_rst_sync.sv
module gpio_evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 8,
  localparam int MODE_W  = 2 * NUM_PADS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [NUM_PADS-1:0] inv_i,
  output logic [NUM_PADS-1:0] evt_o
);
  logic [NUM_PADS-1:0] hist_q;
  logic [NUM_PADS-1:0] hist_d;

  always_comb hist_d = pad_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
    logic      cur_adj;
    logic      old_adj;
    evt_mode_e mode;

    always_comb begin
      mode    = evt_mode_e'(mode_i[2*k +: 2]);
      cur_adj = pad_i[k] ^ inv_i[k];
      old_adj = hist_q[k] ^ inv_i[k];
      unique case (mode)
        EVT_LEVEL: evt_o[k] = cur_adj;
        EVT_EDGE:  evt_o[k] = cur_adj & ~old_adj;
        EVT_ANY:   evt_o[k] = pad_i[k] ^ hist_q[k];
        default:   evt_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] evt_i,
  input  logic                wr_i,
  input  logic                addr_i,
  input  logic [NUM_PADS-1:0] wdata_i,
  output logic [NUM_PADS-1:0] pend_o,
  output logic [NUM_PADS-1:0] mask_o
);
  logic [NUM_PADS-1:0] pend_q, pend_d;
  logic [NUM_PADS-1:0] mask_q, mask_d;
  logic [NUM_PADS-1:0] clr_bits;
  logic                mask_we;

  always_comb begin
    clr_bits = (wr_i && addr_i == ADDR_PEND) ? wdata_i : '0;
    mask_we  = wr_i && addr_i == ADDR_MASK;
    pend_d   = (pend_q & ~clr_bits) | evt_i;
    mask_d   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
  parameter int NUM_PADS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pend_i,
  input  logic [NUM_PADS-1:0] mask_i,
  output logic                irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |(pend_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_event_detector.sv
module gpio_event_detector
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS   = 8,
  parameter int RST_STAGES = 2,
  localparam int MODE_W    = 2 * NUM_PADS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic [MODE_W-1:0]   evt_mode_i,
  input  logic [NUM_PADS-1:0] pad_inv_i,
  input  logic                reg_wr_i,
  input  logic                reg_addr_i,
  input  logic [NUM_PADS-1:0] reg_wdata_i,
  output logic [NUM_PADS-1:0] reg_rdata_o,
  output logic                irq_o
);
  logic                rst_q;
  logic [NUM_PADS-1:0] evt;
  logic [NUM_PADS-1:0] status_q;
  logic [NUM_PADS-1:0] enable_q;

  gpio_evt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n_i(rst_n), .rst_n_o(rst_q)
  );

  gpio_evt_detect #(.NUM_PADS(NUM_PADS)) u_det (
    .clk(clk), .rst_n(rst_q), .pad_i(pad_i), .mode_i(evt_mode_i),
    .inv_i(pad_inv_i), .evt_o(evt)
  );

  gpio_evt_regs #(.NUM_PADS(NUM_PADS)) u_regs (
    .clk(clk), .rst_n(rst_q), .evt_i(evt), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .pend_o(status_q), .mask_o(enable_q)
  );

  gpio_evt_irq #(.NUM_PADS(NUM_PADS)) u_irq (
    .clk(clk), .rst_n(rst_q), .pend_i(status_q), .mask_i(enable_q),
    .irq_o(irq_o)
  );

  always_comb reg_rdata_o = (reg_addr_i == ADDR_MASK) ? enable_q : status_q;
endmodule

// File: rtl/gpio_evt_checker.sv
module gpio_evt_checker #(
  parameter int NUM_PADS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PADS-1:0]   pad,
  input logic [2*NUM_PADS-1:0] mode,
  input logic [NUM_PADS-1:0]   inv,
  input logic                  wr,
  input logic                  addr,
  input logic [NUM_PADS-1:0]   wdata,
  input logic [NUM_PADS-1:0]   status,
  input logic [NUM_PADS-1:0]   enable,
  input logic                  irq
);
  logic [NUM_PADS-1:0] off_pads;
  logic [NUM_PADS-1:0] lvl_active;
  logic [NUM_PADS-1:0] clr_req;

  always_comb begin
    for (int k = 0; k < NUM_PADS; k++) begin
      off_pads[k]   = mode[2*k +: 2] == 2'd2;
      lvl_active[k] = (mode[2*k +: 2] == 2'd0) && (pad[k] ^ inv[k]);
    end
    clr_req = (wr && !addr) ? wdata : '0;
  end

  assert_off_never_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(off_pads)) == '0));

  assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~status & ~$past(clr_req)) == '0));

  assert_level_sets_over_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(lvl_active)) == '0));

  assert_irq_registered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & enable))));

  assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr) |=> (enable == $past(wdata)));

  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr) |=> $stable(enable));
endmodule

bind gpio_event_detector gpio_evt_checker #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk(clk), .rst_n(rst_q), .pad(pad_i), .mode(evt_mode_i), .inv(pad_inv_i),
  .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
  .status(status_q), .enable(enable_q), .irq(irq_o)
);

// File: tb/tb_gpio_event_detector.sv
module tb_gpio_event_detector;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   pad;
  logic [2*N-1:0] mode;
  logic [N-1:0]   inv;
  logic           wr;
  logic           addr;
  logic [N-1:0]   wdata;
  logic [N-1:0]   rdata;
  logic           irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [N-1:0] m_stat, m_en, m_prev;
  logic         m_irq;

  always #10 clk = ~clk;

  gpio_event_detector #(.NUM_PADS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .evt_mode_i(mode),
    .pad_inv_i(inv), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [N-1:0] model_evt();
    logic [N-1:0] ev;
    for (int k = 0; k < N; k++) begin
      logic s, ps;
      s  = pad[k] ^ inv[k];
      ps = m_prev[k] ^ inv[k];
      case (mode[2*k +: 2])
        2'd0:    ev[k] = s;
        2'd1:    ev[k] = s & ~ps;
        2'd3:    ev[k] = pad[k] ^ m_prev[k];
        default: ev[k] = 1'b0;
      endcase
    end
    return ev;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input string req);
    logic [N-1:0] ev, clr;
    ev  = model_evt();
    clr = (wr && !addr) ? wdata : '0;
    @(posedge clk);
    #1;
    m_irq = |(m_stat & m_en);
    if (wr && addr) m_en = wdata;
    m_stat = (m_stat & ~clr) | ev;
    m_prev = pad;
    chk(req, 32'(rdata), 32'(addr ? m_en : m_stat));
    chk({req, " irq R8"}, 32'(irq), 32'(m_irq));
  endtask

  task automatic wreg(input logic a, input logic [N-1:0] d, input string req);
    addr = a; wdata = d; wr = 1'b1;
    tick(req);
    wr = 1'b0; addr = 1'b0;
  endtask

  task automatic set_mode(input int k, input logic [1:0] m);
    mode[2*k +: 2] = m;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; pad = '0; inv = '0; wr = 1'b0; addr = 1'b0; wdata = '0;
    mode = {N{2'd2}};
    m_stat = '0; m_en = '0; m_prev = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pending in reset", 32'(rdata), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 pending after reset", 32'(rdata), 0);
    addr = 1'b1; #1;
    chk("R1 enable after reset", 32'(rdata), 0);
    addr = 1'b0;

    // R9 enable load and readback
    wreg(1'b1, 8'h01, "R9 enable write");
    addr = 1'b1; #1;
    chk("R9 enable readback", 32'(rdata), 32'h01);
    addr = 1'b0;

    // R2 level mode, R7 re-set under clear while level persists
    set_mode(0, 2'd0); pad[0] = 1'b1;
    tick("R2 level set");
    chk("R2 level pending bit", 32'(rdata[0]), 1);
    wreg(1'b0, 8'h01, "R7 clear vs level");
    chk("R7 set wins", 32'(rdata[0]), 1);
    tick("R8 irq follows");
    chk("R8 irq high", 32'(irq), 1);
    pad[0] = 1'b0;
    wreg(1'b0, 8'h01, "R6 clear");
    chk("R6 cleared", 32'(rdata[0]), 0);
    inv[0] = 1'b1;
    tick("R2 active-low level");
    chk("R2 active-low pending", 32'(rdata[0]), 1);
    set_mode(0, 2'd2); inv[0] = 1'b0;
    wreg(1'b0, 8'h01, "R6 clear");

    // R3 edge: rising with inv=0, falling with inv=1
    set_mode(1, 2'd1); pad[1] = 1'b1;
    tick("R3 rising edge");
    chk("R3 rising pending", 32'(rdata[1]), 1);
    wreg(1'b0, 8'h02, "R3 clear");
    tick("R3 no repeat on steady high");
    chk("R3 steady high", 32'(rdata[1]), 0);
    inv[1] = 1'b1;
    tick("R10 invert toggle steady");
    chk("R10 no edge from invert", 32'(rdata[1]), 0);
    pad[1] = 1'b0;
    tick("R3 falling edge with invert");
    chk("R3 falling pending", 32'(rdata[1]), 1);
    wreg(1'b0, 8'h02, "R6 clear");
    pad[1] = 1'b1;
    tick("R3 rising ignored with invert");
    chk("R3 rise under invert", 32'(rdata[1]), 0);

    // R4 any-transition ignores invert
    set_mode(2, 2'd3); inv[2] = 1'b1; pad[2] = 1'b1;
    tick("R4 rise");
    chk("R4 rise pending", 32'(rdata[2]), 1);
    wreg(1'b0, 8'h04, "R4 clear");
    pad[2] = 1'b0;
    tick("R4 fall");
    chk("R4 fall pending", 32'(rdata[2]), 1);

    // R5 off mode
    set_mode(3, 2'd2);
    for (int i = 0; i < 6; i++) begin
      pad[3] = ~pad[3]; inv[3] = i[1];
      tick("R5 off mode");
      chk("R5 off pending", 32'(rdata[3]), 0);
    end

    // R11 mask all and clear
    wreg(1'b1, 8'hFF, "R9 enable all");
    wreg(1'b1, 8'h00, "R11 mask all");
    wreg(1'b0, 8'hFF, "R11 clear all");
    tick("R11 settle");
    chk("R11 pending zero", 32'(rdata), 0);
    chk("R11 irq low", 32'(irq), 0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) begin
        mode = 16'($urandom);
        inv  = 8'($urandom);
      end
      pad = ($urandom % 4 == 0) ? 8'($urandom) : pad;
      if ($urandom % 16 == 0) inv[$urandom % N] ^= 1'b1;
      wr    = ($urandom % 4 == 0);
      addr  = 1'($urandom);
      wdata = 8'($urandom);
      tick(addr ? "R9 random readback" : "R6 random pending");
      wr = 1'b0;
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule